// File: doc/BRIEF.md
# Atomic Event Sequence Monitor

This block sits beside the retirement stage of a core and watches the memory-reference instructions that form one multi-line atomic event. It follows the event through two phases. In the setup phase, locked loads and locked prefetches name the cache lines that take part in the event. In the manifestation phase, stores modify those lines. A small table holds the participating line addresses. The table is compared at cache-line granularity, so any two addresses inside the same line count as one entry.

The monitor raises a one-cycle fault pulse with a cause code when the instruction stream breaks the ordering rules:

- a participating read arrives after modification has started;
- a second boundary query arrives;
- the table would need more lines than it holds;
- a locked store appears with no event open.

The single locked store that closes a legal event produces a one-cycle completion pulse. After a fault or a completion, the monitor goes back to idle with an empty table. The cache actions, the detection of interference from other agents, and any retry of the event are handled elsewhere.

All outputs are registered. An instruction sampled at one rising edge shows its effect on the outputs from that same edge on, so the result can be read in the cycle that follows.

Top module: `atom_seq_guard`

## Requirements
- R1: After reset, and until a valid instruction changes it, the phase output is 0 (idle), and fault, cause and done are all 0. The phase encoding is 0 = idle, 1 = setup, 2 = manifestation.
- R2: In idle, a valid locked load or locked prefetch moves the phase to setup in the next cycle. It empties the line table and records that instruction's line as the only entry.
- R3: In setup, a valid query moves the phase to manifestation in the next cycle.
- R4: In setup, a store whose line is in the table moves the phase to manifestation. A store to a line that is not in the table leaves the phase in setup and raises no fault.
- R5: In manifestation, a locked load or locked prefetch raises the fault pulse with cause 01 (ordering). This holds even when the line is already in the table.
- R6: A plain load never raises a fault and never changes the phase, in any phase.
- R7: In setup, a locked load or locked prefetch to a line that is not yet in the table, when the table already holds DEPTH lines, raises the fault pulse with cause 10 (overflow). Addresses that differ only in their low log2(LINE_BYTES) bits name the same line and use one entry.
- R8: A locked store in setup or in manifestation gives a one-cycle done pulse and returns the phase to idle. A locked store in idle raises the fault pulse with cause 11.
- R9: After any fault, the phase is idle in the next cycle and the table is empty, so a new event can again record DEPTH distinct lines.
- R10: In manifestation, a query raises the fault pulse with cause 01. Plain stores in manifestation are accepted without a fault.
- R11: The instruction class encoding is 0 locked load, 1 locked prefetch, 2 plain load, 3 query, 4 store, 5 locked store. Codes 6 and 7, and any cycle with the valid strobe low, have no effect on any output.
- R12: Fault and done are never high in the same cycle, and the cause output is 00 whenever fault is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A retired instruction is present this cycle |
| in_op | input | 3 | Instruction class (encoding in R11) |
| in_addr | input | ADDR_W | Byte address of the reference |
| phase_o | output | 2 | Current phase: 0 idle, 1 setup, 2 manifestation |
| fault_o | output | 1 | One-cycle operation fault pulse |
| fault_cause_o | output | 2 | Fault cause: 01 ordering, 10 overflow, 11 locked store outside an event |
| done_o | output | 1 | One-cycle event-complete pulse |

## Verification
The bench builds the monitor with DEPTH = 4, ADDR_W = 32 and LINE_BYTES = 64. With the shallow table, both sides of the capacity limit can be reached in a few instructions: a full table that still accepts repeated lines, and the overflow fault on the fifth distinct line. The 64-byte lines let the bench send addresses that share a line but differ in their offset bits, which tests the line-granularity matching. The bench also checks that a fresh event after an overflow can fill the whole table again.

// File: rtl/atom_seq_pkg.sv
package atom_seq_pkg;

   // instruction class encoding at the block edge
   localparam logic [2:0] OP_LK_LD  = 3'd0;
   localparam logic [2:0] OP_LK_PF  = 3'd1;
   localparam logic [2:0] OP_PL_LD  = 3'd2;
   localparam logic [2:0] OP_QUERY  = 3'd3;
   localparam logic [2:0] OP_ST     = 3'd4;
   localparam logic [2:0] OP_LK_ST  = 3'd5;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_MANIF = 2'd2
   } phase_e;

   localparam logic [1:0] CAUSE_NONE  = 2'b00;
   localparam logic [1:0] CAUSE_ORDER = 2'b01;
   localparam logic [1:0] CAUSE_OVFL  = 2'b10;
   localparam logic [1:0] CAUSE_STRAY = 2'b11;

   // decoded, valid-qualified class flags
   typedef struct packed {
      logic lk_in;   // locked load or locked prefetch
      logic query;
      logic st;
      logic lk_st;
   } opcls_t;

endpackage

// File: rtl/atom_seq_decode.sv
module atom_seq_decode
   import atom_seq_pkg::*;
(
   input  logic       valid_i,
   input  logic [2:0] op_i,
   output opcls_t     cls_o
);

   always_comb begin
      cls_o = '0;
      if (valid_i) begin
         unique case (op_i)
            OP_LK_LD, OP_LK_PF: cls_o.lk_in = 1'b1;
            OP_QUERY:           cls_o.query = 1'b1;
            OP_ST:              cls_o.st    = 1'b1;
            OP_LK_ST:           cls_o.lk_st = 1'b1;
            default:            cls_o       = '0;   // plain load and spare codes
         endcase
      end
   end

endmodule

// File: rtl/atom_seq_table.sv
module atom_seq_table #(
   parameter int unsigned TAG_W = 26,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             ins_i,
   input  logic [TAG_W-1:0] tag_i,
   output logic             hit_o,
   output logic             full_o,
   output logic [CNT_W-1:0] count_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("atom_seq_table: DEPTH must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("atom_seq_table: TAG_W must be at least 1");
   end

   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [DEPTH-1:0] vld_q;
   logic [DEPTH-1:0] match;
   logic [CNT_W-1:0] cnt_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign match[i] = vld_q[i] && (tag_q[i] == tag_i);
   end

   assign hit_o   = |match;
   assign full_o  = (cnt_q == CNT_W'(DEPTH));
   assign count_o = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
      end else if (clear_i) begin
         vld_q <= '0;
         cnt_q <= ins_i ? CNT_W'(1) : '0;
         if (ins_i) begin
            vld_q[0] <= 1'b1;
            tag_q[0] <= tag_i;
         end
      end else if (ins_i && !full_o) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CNT_W'(i)) begin
               vld_q[i] <= 1'b1;
               tag_q[i] <= tag_i;
            end
         end
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   AST_TBL_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_i && !clear_i) |-> !full_o); // R7

endmodule

// File: rtl/atom_seq_ctrl.sv
module atom_seq_ctrl
   import atom_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  opcls_t     cls_i,
   input  logic       hit_i,
   input  logic       full_i,
   output logic       tbl_clear_o,
   output logic       tbl_ins_o,
   output logic [1:0] phase_o,
   output logic       fault_o,
   output logic [1:0] cause_o,
   output logic       done_o
);

   phase_e     ph_q, ph_n;
   logic       flt_n, dn_n, clr_n, ins_n;
   logic [1:0] cs_n;
   logic       fault_q, done_q;
   logic [1:0] cause_q;

   always_comb begin
      ph_n  = ph_q;
      flt_n = 1'b0;
      cs_n  = CAUSE_NONE;
      dn_n  = 1'b0;
      clr_n = 1'b0;
      ins_n = 1'b0;
      unique case (ph_q)
         PH_IDLE: begin
            if (cls_i.lk_in) begin
               ph_n  = PH_SETUP;
               clr_n = 1'b1;
               ins_n = 1'b1;
            end else if (cls_i.lk_st) begin
               flt_n = 1'b1;
               cs_n  = CAUSE_STRAY;
            end
         end
         PH_SETUP: begin
            if (cls_i.lk_in) begin
               if (!hit_i) begin
                  if (full_i) begin
                     flt_n = 1'b1;
                     cs_n  = CAUSE_OVFL;
                  end else begin
                     ins_n = 1'b1;
                  end
               end
            end else if (cls_i.query) begin
               ph_n = PH_MANIF;
            end else if (cls_i.st && hit_i) begin
               ph_n = PH_MANIF;
            end else if (cls_i.lk_st) begin
               dn_n  = 1'b1;
               ph_n  = PH_IDLE;
               clr_n = 1'b1;
            end
         end
         PH_MANIF: begin
            if (cls_i.lk_in || cls_i.query) begin
               flt_n = 1'b1;
               cs_n  = CAUSE_ORDER;
            end else if (cls_i.lk_st) begin
               dn_n  = 1'b1;
               ph_n  = PH_IDLE;
               clr_n = 1'b1;
            end
         end
         default: ph_n = PH_IDLE;
      endcase
      if (flt_n) begin
         ph_n  = PH_IDLE;
         clr_n = 1'b1;
         ins_n = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         fault_q <= 1'b0;
         cause_q <= CAUSE_NONE;
         done_q  <= 1'b0;
      end else begin
         ph_q    <= ph_n;
         fault_q <= flt_n;
         cause_q <= cs_n;
         done_q  <= dn_n;
      end
   end

   assign tbl_clear_o = clr_n;
   assign tbl_ins_o   = ins_n;
   assign phase_o     = ph_q;
   assign fault_o     = fault_q;
   assign cause_o     = cause_q;
   assign done_o      = done_q;

   AST_FAULT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |-> (ph_q == PH_IDLE)); // R9
   AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (ph_q == PH_IDLE)); // R8
   AST_MANIF_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_MANIF && !$stable(ph_q)) |-> ($past(ph_q) == PH_SETUP)); // R3

endmodule

// File: rtl/atom_seq_guard.sv
module atom_seq_guard
   import atom_seq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 48,
   parameter int unsigned LINE_BYTES = 64,
   parameter int unsigned DEPTH      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_op,
   input  logic [ADDR_W-1:0] in_addr,
   output logic [1:0]        phase_o,
   output logic              fault_o,
   output logic [1:0]        fault_cause_o,
   output logic              done_o
);

   localparam int unsigned OFFS_W = $clog2(LINE_BYTES);
   localparam int unsigned TAG_W  = ADDR_W - OFFS_W;
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("atom_seq_guard: LINE_BYTES must be a power of two, at least 2");
   end
   if (ADDR_W <= OFFS_W) begin : g_bad_addr
      $error("atom_seq_guard: ADDR_W must exceed the line offset width");
   end

   opcls_t           cls;
   logic             hit, full, tbl_clear, tbl_ins;
   logic [CNT_W-1:0] tbl_count;
   logic [TAG_W-1:0] line_tag;
   logic             unused_offs;

   assign line_tag    = in_addr[ADDR_W-1:OFFS_W];
   assign unused_offs = ^in_addr[OFFS_W-1:0];

   atom_seq_decode u_dec (
      .valid_i (in_valid),
      .op_i    (in_op),
      .cls_o   (cls)
   );

   atom_seq_table #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (tbl_clear),
      .ins_i   (tbl_ins),
      .tag_i   (line_tag),
      .hit_o   (hit),
      .full_o  (full),
      .count_o (tbl_count)
   );

   atom_seq_ctrl u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cls_i       (cls),
      .hit_i       (hit),
      .full_i      (full),
      .tbl_clear_o (tbl_clear),
      .tbl_ins_o   (tbl_ins),
      .phase_o     (phase_o),
      .fault_o     (fault_o),
      .cause_o     (fault_cause_o),
      .done_o      (done_o)
   );

   AST_SETUP_HAS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_SETUP) |-> (tbl_count != '0)); // R2
   AST_IDLE_EMPTY_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (tbl_count == '0)); // R9
   AST_LATE_INBOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_MANIF && in_valid && (in_op == OP_LK_LD || in_op == OP_LK_PF))
      |=> (fault_o && fault_cause_o == CAUSE_ORDER)); // R5
   AST_STRAY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_IDLE && in_valid && in_op == OP_LK_ST)
      |=> (fault_o && fault_cause_o == CAUSE_STRAY)); // R8
   AST_PLAIN_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == OP_PL_LD) |=> (!fault_o && $stable(phase_o))); // R6
   AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(fault_o && done_o) && (fault_o || fault_cause_o == CAUSE_NONE)); // R12

endmodule

// File: tb/sim_atom_seq_guard.sv
module sim_atom_seq_guard;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int LB = 64;
   localparam int DP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [2:0]    in_op = 3'd0;
   logic [AW-1:0] in_addr = '0;
   logic [1:0]    phase_o;
   logic          fault_o;
   logic [1:0]    fault_cause_o;
   logic          done_o;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // reference model state
   int m_ph = 0;
   int m_flt = 0;
   int m_cs = 0;
   int m_dn = 0;
   int unsigned m_lines[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   atom_seq_guard #(.ADDR_W(AW), .LINE_BYTES(LB), .DEPTH(DP)) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_op         (in_op),
      .in_addr       (in_addr),
      .phase_o       (phase_o),
      .fault_o       (fault_o),
      .fault_cause_o (fault_cause_o),
      .done_o        (done_o)
   );

   task automatic model(input bit v, input int op, input int unsigned addr);
      int unsigned ln;
      bit hit;
      ln = addr / LB;
      hit = 0;
      foreach (m_lines[k]) if (m_lines[k] == ln) hit = 1;
      m_flt = 0; m_cs = 0; m_dn = 0;
      if (!v) return;
      if (m_ph == 0) begin
         if (op == 0 || op == 1) begin
            m_lines.delete(); m_lines.push_back(ln); m_ph = 1;
         end else if (op == 5) begin
            m_flt = 1; m_cs = 3;
         end
      end else if (m_ph == 1) begin
         if (op == 0 || op == 1) begin
            if (!hit) begin
               if (m_lines.size() == DP) begin m_flt = 1; m_cs = 2; end
               else m_lines.push_back(ln);
            end
         end else if (op == 3) m_ph = 2;
         else if (op == 4 && hit) m_ph = 2;
         else if (op == 5) begin m_dn = 1; m_ph = 0; m_lines.delete(); end
      end else begin
         if (op == 0 || op == 1 || op == 3) begin m_flt = 1; m_cs = 1; end
         else if (op == 5) begin m_dn = 1; m_ph = 0; m_lines.delete(); end
      end
      if (m_flt != 0) begin m_ph = 0; m_lines.delete(); end
   endtask

   task automatic compare(input string req);
      checks++;
      if (phase_o !== 2'(m_ph) || fault_o !== 1'(m_flt) ||
          fault_cause_o !== 2'(m_cs) || done_o !== 1'(m_dn)) begin
         errors++;
         $display("FAIL %s: phase=%0d fault=%0b cause=%0d done=%0b expected phase=%0d fault=%0d cause=%0d done=%0d",
                  req, phase_o, fault_o, fault_cause_o, done_o, m_ph, m_flt, m_cs, m_dn);
      end
   endtask

   task automatic step(input bit v, input int op, input int unsigned addr, input string req);
      @(negedge clk);
      in_valid = v;
      in_op    = 3'(op);
      in_addr  = AW'(addr);
      @(posedge clk);
      #1;
      model(v, op, addr);
      compare(req);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      compare("R1 after reset");
      step(0, 5, 32'h0, "R11 valid low");
      step(1, 6, 32'h1000, "R11 spare code idle");
      compare("R1 idle held");

      // normal event with store-started manifestation
      step(1, 0, 32'h1000, "R2 enter setup");
      step(1, 2, 32'h2000, "R6 plain load setup");
      step(1, 4, 32'h3000, "R4 store to other line");
      step(1, 1, 32'h2000, "R2 locked prefetch");
      step(1, 7, 32'h4000, "R11 spare code setup");
      step(1, 4, 32'h1008, "R4 store to participating line");
      step(1, 2, 32'h5000, "R6 plain load manif");
      step(1, 4, 32'h6000, "R10 plain store manif");
      step(1, 5, 32'h1000, "R8 locked store done");
      step(0, 0, 32'h0, "R8 done pulse ends");

      // query boundary then late locked read
      step(1, 1, 32'h7000, "R2 enter setup");
      step(1, 3, 32'h0, "R3 query");
      step(1, 6, 32'h7000, "R11 spare code manif");
      step(1, 0, 32'h7000, "R5 late locked load");
      step(0, 0, 32'h0, "R9 idle after fault");

      // stray locked store
      step(1, 5, 32'h8000, "R8 stray locked store");
      step(0, 0, 32'h0, "R12 fault pulse ends");

      // overflow
      step(1, 0, 32'h10000, "R2 enter setup");
      step(1, 1, 32'h10040, "R7 second line");
      step(1, 0, 32'h10080, "R7 third line");
      step(1, 0, 32'h100C0, "R7 fourth line");
      step(1, 1, 32'h10004, "R7 same line other offset");
      step(1, 0, 32'h100FF, "R7 repeat while full");
      step(1, 0, 32'h10100, "R7 overflow");
      step(0, 0, 32'h0, "R9 idle after overflow");

      // fresh event fills again, then second query
      step(1, 0, 32'h20000, "R9 new event");
      step(1, 0, 32'h20040, "R9 refill");
      step(1, 0, 32'h20080, "R9 refill");
      step(1, 1, 32'h200C0, "R9 refill to limit");
      step(1, 3, 32'h0, "R3 query");
      step(1, 2, 32'h0, "R6 plain load manif");
      step(1, 3, 32'h0, "R10 second query");
      step(1, 2, 32'h0, "R6 plain load idle");

      // locked store straight from setup
      step(1, 0, 32'h30000, "R2 enter setup");
      step(1, 5, 32'h30000, "R8 locked store from setup");
      step(1, 4, 32'h30000, "R4 store in idle ignored");
      step(0, 0, 32'h0, "R12 quiet");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule